// File: doc/BRIEF.md
# Hard-Decision Bit-Flipping Parity-Check Decoder

This block decodes a short binary low-density parity-check code with hard bit decisions as input. The parity-check matrix is a parameter fixed at elaboration. A start pulse loads a word. On every following clock the block forms the syndrome of the word it holds. It counts, for each bit, how many failing parity rows touch that bit, and it inverts every bit whose count equals the largest count. The loop ends as soon as all rows are satisfied, or when the number of flip rounds reaches a cap.

When the block finishes it raises a one-cycle done pulse. The corrected word, a success flag and the number of flip rounds used stay on the outputs until the next start. The cap is given per decode on an input. A zero on that input selects a parameter default.

Top module: `bf_ldpc_decoder`

## Requirements
- R1: After reset, busy_o, done_o and success_o are 0, and word_o and iter_o are all zeros.
- R2: A start_i high while idle captures word_i and the cap. busy_o is 1 and iter_o is 0 from the next cycle.
- R3: If the held word satisfies every parity row at an evaluation, the decode ends with success_o=1. word_o is left unchanged at that point. A valid input codeword finishes with iter_o=0.
- R4: Each clock while busy is one iteration. Every bit whose failing-row count equals the largest count (all tied bits, when that count is at least 1) is inverted, and iter_o rises by one. done_o appears iter_o+1 clocks after the start edge.
- R5: If no valid word is reached, the decode ends with success_o=0 when iter_o equals the cap. iter_o never exceeds the cap.
- R6: A cap input of 0 selects the DEF_MAX_ITER parameter (default 16) as the cap.
- R7: done_o is high for exactly one cycle, and busy_o is low whenever done_o is high. word_o, success_o and iter_o hold until the next accepted start.
- R8: A start_i pulse while busy has no effect on the decode in progress.
- R9: success_o=1 only when word_o satisfies every parity row.
- R10: Row m of the parity-check matrix uses bit m*N+n of H_MAT for column n. The default matrix (N=7, M=3) sets row m in column n exactly when bit m of n+1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a decode of word_i (taken only while idle) |
| word_i | input | N | Hard-decision input word |
| max_iter_i | input | ITER_W | Flip-round cap; 0 selects DEF_MAX_ITER |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| success_o | output | 1 | Final word satisfies all parity rows |
| word_o | output | N | Held / corrected word |
| iter_o | output | ITER_W | Flip rounds performed |

## Verification
The hardest condition to reach is a decode that never converges and runs into the cap. With the default matrix, a single error in column 0 produces a tie among four bits. Flipping all four leads back to the same syndrome, so the word oscillates forever. The stimulus uses that pattern with small caps and with a zero cap, which exercises both an odd and an even number of oscillation steps as well as the default cap. A second pattern injects a start pulse partway through such an oscillating decode to show that the pulse is ignored.

// File: rtl/ldpc_bf_pkg.sv
package ldpc_bf_pkg;

   typedef enum logic [0:0] {
      BF_IDLE = 1'b0,
      BF_RUN  = 1'b1
   } bf_state_e;

   // width that holds values 0..v
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned w;
      w = 1;
      while ((1 << w) <= v) w++;
      return w;
   endfunction

endpackage

// File: rtl/bf_syndrome.sv
module bf_syndrome #(
   parameter int unsigned          N     = 7,
   parameter int unsigned          M     = 3,
   parameter logic [M*N-1:0]       H_MAT = '0
) (
   input  logic [N-1:0] word_i,
   output logic [M-1:0] syn_o
);

   // one parity equation per matrix row
   for (genvar m = 0; m < M; m++) begin : g_row
      assign syn_o[m] = ^(word_i & H_MAT[m*N +: N]);
   end

endmodule

// File: rtl/bf_unsat_count.sv
module bf_unsat_count #(
   parameter int unsigned          N     = 7,
   parameter int unsigned          M     = 3,
   parameter int unsigned          CW    = 2,
   parameter logic [M*N-1:0]       H_MAT = '0
) (
   input  logic [M-1:0]    syn_i,
   output logic [N*CW-1:0] cnt_o
);

   // per column: number of failing rows that touch it
   for (genvar n = 0; n < N; n++) begin : g_col
      logic [CW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int m = 0; m < M; m++) begin
            acc = acc + CW'(syn_i[m] & H_MAT[m*N + n]);
         end
      end
      assign cnt_o[n*CW +: CW] = acc;
   end

endmodule

// File: rtl/bf_flip_select.sv
module bf_flip_select #(
   parameter int unsigned N  = 7,
   parameter int unsigned CW = 2
) (
   input  logic [N*CW-1:0] cnt_i,
   output logic [CW-1:0]   max_o,
   output logic [N-1:0]    mask_o
);

   always_comb begin
      max_o = '0;
      for (int n = 0; n < N; n++) begin
         if (cnt_i[n*CW +: CW] > max_o) max_o = cnt_i[n*CW +: CW];
      end
   end

   // every column tied at the maximum flips, never at a zero maximum
   for (genvar n = 0; n < N; n++) begin : g_mask
      assign mask_o[n] = (max_o != '0) && (cnt_i[n*CW +: CW] == max_o);
   end

endmodule

// File: rtl/bf_ldpc_decoder.sv
module bf_ldpc_decoder #(
   parameter int unsigned          N            = 7,
   parameter int unsigned          M            = 3,
   parameter int unsigned          ITER_W       = 5,
   parameter int unsigned          DEF_MAX_ITER = 16,
   parameter logic [M*N-1:0]       H_MAT        = 21'b1111000_1100110_1010101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [N-1:0]      word_i,
   input  logic [ITER_W-1:0] max_iter_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              success_o,
   output logic [N-1:0]      word_o,
   output logic [ITER_W-1:0] iter_o
);

   import ldpc_bf_pkg::*;

   localparam int unsigned CW = bits_for(M);

   // elaboration-time parameter checks
   if (N < 2) begin : g_bad_n
      $error("bf_ldpc_decoder: N must be at least 2");
   end
   if (M < 1) begin : g_bad_m
      $error("bf_ldpc_decoder: M must be at least 1");
   end
   if (DEF_MAX_ITER < 1 || DEF_MAX_ITER >= (1 << ITER_W)) begin : g_bad_cap
      $error("bf_ldpc_decoder: DEF_MAX_ITER must fit in ITER_W and be nonzero");
   end

   bf_state_e         state_q;
   logic [N-1:0]      word_q;
   logic [ITER_W-1:0] iter_q;
   logic [ITER_W-1:0] cap_q;
   logic              done_q;
   logic              succ_q;

   logic [M-1:0]      syn;
   logic [N*CW-1:0]   cnt;
   logic [CW-1:0]     cnt_max;
   logic [N-1:0]      flip_mask;

   bf_syndrome #(.N(N), .M(M), .H_MAT(H_MAT)) u_syn (
      .word_i (word_q),
      .syn_o  (syn)
   );

   bf_unsat_count #(.N(N), .M(M), .CW(CW), .H_MAT(H_MAT)) u_cnt (
      .syn_i  (syn),
      .cnt_o  (cnt)
   );

   bf_flip_select #(.N(N), .CW(CW)) u_sel (
      .cnt_i  (cnt),
      .max_o  (cnt_max),
      .mask_o (flip_mask)
   );

   logic syn_clear;
   logic at_cap;
   logic stuck;
   logic [ITER_W-1:0] cap_sel;

   assign syn_clear = (syn == '0);
   assign at_cap    = (iter_q == cap_q);
   assign stuck     = (cnt_max == '0);
   assign cap_sel   = (max_iter_i == '0) ? ITER_W'(DEF_MAX_ITER) : max_iter_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BF_IDLE;
         word_q  <= '0;
         iter_q  <= '0;
         cap_q   <= '0;
         done_q  <= 1'b0;
         succ_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            BF_IDLE: begin
               if (start_i) begin
                  state_q <= BF_RUN;
                  word_q  <= word_i;
                  iter_q  <= '0;
                  cap_q   <= cap_sel;
                  succ_q  <= 1'b0;
               end
            end
            BF_RUN: begin
               if (syn_clear) begin
                  state_q <= BF_IDLE;
                  done_q  <= 1'b1;
                  succ_q  <= 1'b1;
               end else if (at_cap || stuck) begin
                  state_q <= BF_IDLE;
                  done_q  <= 1'b1;
                  succ_q  <= 1'b0;
               end else begin
                  word_q <= word_q ^ flip_mask;
                  iter_q <= iter_q + 1'b1;
               end
            end
            default: state_q <= BF_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q == BF_RUN);
   assign done_o    = done_q;
   assign success_o = succ_q;
   assign word_o    = word_q;
   assign iter_o    = iter_q;

endmodule

// File: rtl/bf_ldpc_checker.sv
module bf_ldpc_checker #(
   parameter int unsigned          N            = 7,
   parameter int unsigned          M            = 3,
   parameter int unsigned          ITER_W       = 5,
   parameter int unsigned          DEF_MAX_ITER = 16,
   parameter logic [M*N-1:0]       H_MAT        = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ITER_W-1:0] max_iter_i,
   input  logic              busy_o,
   input  logic              done_o,
   input  logic              success_o,
   input  logic [N-1:0]      word_o,
   input  logic [ITER_W-1:0] iter_o
);

   logic [ITER_W-1:0] chk_cap_q;
   logic              rows_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_cap_q <= '0;
      else if (start_i && !busy_o)
         chk_cap_q <= (max_iter_i == '0) ? ITER_W'(DEF_MAX_ITER) : max_iter_i;
   end

   always_comb begin
      rows_ok = 1'b1;
      for (int m = 0; m < M; m++) begin
         if (^(word_o & H_MAT[m*N +: N])) rows_ok = 1'b0;
      end
   end

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && iter_o == '0));                  // R2
   AST_ITER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (iter_o == $past(iter_o) + 1'b1));     // R4
   AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (iter_o <= chk_cap_q));                                   // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                 // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);                                                 // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(word_o) && $stable(iter_o) && $stable(success_o))); // R7
   AST_SUCCESS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && success_o) |-> rows_ok);                                  // R9

endmodule

bind bf_ldpc_decoder bf_ldpc_checker #(
   .N(N), .M(M), .ITER_W(ITER_W), .DEF_MAX_ITER(DEF_MAX_ITER), .H_MAT(H_MAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .max_iter_i (max_iter_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .success_o  (success_o),
   .word_o     (word_o),
   .iter_o     (iter_o)
);

// File: tb/sim_bf_ldpc_decoder.sv
module sim_bf_ldpc_decoder;

   localparam int N  = 7;
   localparam int M  = 3;
   localparam int IW = 5;
   localparam int NV = 10;

   localparam logic [N-1:0]  TV_WORD [NV] = '{7'b0000000, 7'b1111111, 7'b1000000,
      7'b0000010, 7'b0000100, 7'b0001000, 7'b0110000, 7'b0100001, 7'b1010101, 7'b0010110};
   localparam logic [IW-1:0] TV_CAP  [NV] = '{5'd4, 5'd4, 5'd4, 5'd4, 5'd4, 5'd6,
      5'd2, 5'd5, 5'd3, 5'd7};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [N-1:0]  word_i = '0;
   logic [IW-1:0] max_iter_i = '0;
   logic          busy_o, done_o, success_o;
   logic [N-1:0]  word_o;
   logic [IW-1:0] iter_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   bf_ldpc_decoder u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
      .max_iter_i(max_iter_i), .busy_o(busy_o), .done_o(done_o),
      .success_o(success_o), .word_o(word_o), .iter_o(iter_o)
   );

   // default matrix from R10: row m, column n set when bit m of n+1 is 1
   function automatic bit hbit(int m, int n);
      return bit'(((n + 1) >> m) & 1);
   endfunction

   function automatic logic [M-1:0] syndrome(logic [N-1:0] w);
      logic [M-1:0] s;
      for (int m = 0; m < M; m++) begin
         s[m] = 1'b0;
         for (int n = 0; n < N; n++) s[m] = s[m] ^ (w[n] & hbit(m, n));
      end
      return s;
   endfunction

   task automatic ref_decode(input logic [N-1:0] w, input int cap,
                             output logic [N-1:0] wo, output int it, output bit ok);
      int cnt [N];
      int mx;
      logic [M-1:0] s;
      if (cap == 0) cap = 16;
      wo = w; it = 0; ok = 1'b0;
      forever begin
         s = syndrome(wo);
         if (s == '0) begin ok = 1'b1; break; end
         if (it == cap) break;
         mx = 0;
         for (int n = 0; n < N; n++) begin
            cnt[n] = 0;
            for (int m = 0; m < M; m++) cnt[n] += int'(s[m] & hbit(m, n));
            if (cnt[n] > mx) mx = cnt[n];
         end
         if (mx == 0) break;
         for (int n = 0; n < N; n++) if (cnt[n] == mx) wo[n] = ~wo[n];
         it++;
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one decode; optionally inject a start during the run
   task automatic run_case(input logic [N-1:0] w, input logic [IW-1:0] cap, input bit inject,
                           output logic [N-1:0] gw, output int git, output bit gok);
      logic [N-1:0] ew;
      int eit;
      bit eok;
      int edges;
      ref_decode(w, int'(cap), ew, eit, eok);
      @(negedge clk);
      start_i = 1'b1; word_i = w; max_iter_i = cap;
      @(negedge clk);
      start_i = 1'b0; word_i = ~w; max_iter_i = 5'd1;
      chk("R2 busy after start", int'(busy_o), 1);
      chk("R2 iter cleared", int'(iter_o), 0);
      edges = 0;
      while (!done_o && edges < 100) begin
         if (inject && edges == 1) start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         edges++;
      end
      chk("R4 done latency", edges, eit + 1);
      chk("R4/R5 word", int'(word_o), int'(ew));
      chk("R3/R5 success", int'(success_o), int'(eok));
      chk("R4/R5 iterations", int'(iter_o), eit);
      chk("R7 done low while busy", int'(busy_o), 0);
      if (success_o) chk("R9 word satisfies rows", int'(syndrome(word_o)), 0);
      gw = word_o; git = int'(iter_o); gok = success_o;
      @(negedge clk);
      chk("R7 done one cycle", int'(done_o), 0);
      repeat (2) @(negedge clk);
      chk("R7 word held", int'(word_o), int'(gw));
      chk("R7 iter held", int'(iter_o), git);
      chk("R7 success held", int'(success_o), int'(gok));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [N-1:0] gw;
      int git;
      bit gok;
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 done", int'(done_o), 0);
      chk("R1 success", int'(success_o), 0);
      chk("R1 word", int'(word_o), 0);
      chk("R1 iter", int'(iter_o), 0);
      rst_n = 1'b1;

      // R10 default matrix, table of patterns
      for (int i = 0; i < NV; i++) begin
         run_case(TV_WORD[i], TV_CAP[i], 1'b0, gw, git, gok);
      end

      // R3 valid codeword: immediate success, no flips
      run_case(7'b1111111, 5'd4, 1'b0, gw, git, gok);
      chk("R3 codeword iter", git, 0);
      chk("R3 codeword word", int'(gw), 7'h7f);
      chk("R3 codeword success", int'(gok), 1);

      // R4 single error in column 6: only that bit has count 3
      run_case(7'b1000000, 5'd4, 1'b0, gw, git, gok);
      chk("R4 single flip word", int'(gw), 0);
      chk("R4 single flip iter", git, 1);

      // R5 oscillating tie pattern hits the cap (odd steps)
      run_case(7'b0000001, 5'd3, 1'b0, gw, git, gok);
      chk("R5 cap word", int'(gw), 7'b1010100);
      chk("R5 cap iter", git, 3);
      chk("R5 cap success", int'(gok), 0);

      // R6 zero cap means default 16 (even steps return the input)
      run_case(7'b0000001, 5'd0, 1'b0, gw, git, gok);
      chk("R6 default cap iter", git, 16);
      chk("R6 default cap word", int'(gw), 7'b0000001);

      // R8 start pulse mid-run is ignored
      run_case(7'b0000001, 5'd5, 1'b1, gw, git, gok);
      chk("R8 ignored start iter", git, 5);
      chk("R8 ignored start word", int'(gw), 7'b1010100);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule